// File: doc/BRIEF.md
# Thermal Sensor Sampling Controller

This block sits between a temperature-sensing ADC and a 32-bit register port. While sensing is switched on, it raises a one-cycle acquisition request at a fixed programmable interval. The sensor answers with a raw code on a valid/data pair. The block can pass each code straight through or average a power-of-two group of them. It then publishes the result in a read-only data register.

Every published result is compared with three programmable codes: an alarm code, a release (hysteresis) code and a shutdown code. Raw codes fall as temperature rises, so "hotter" means "numerically lower". Events are recorded in sticky status bits, which software clears by writing one. A level interrupt is high whenever an enabled status bit is pending. Converting codes to degrees, calibration storage and the bus fabric are handled elsewhere.

The acquisition interval is (PER+1)·2^UNIT_LOG2 clocks. The default UNIT_LOG2 of 12 gives a unit of 4096 clocks. With averaging on, one result appears every 2^(type+1) intervals.

Top module: `thermo_sample_ctrl`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and `acq_req` is low.
- R2: While the sense enable (bit 0 at 0x40) is set, `acq_req` is high for exactly one cycle every (PER+1)·2^UNIT_LOG2 clocks. PER is the field at bits 27:12 of 0x44.
- R3: With the filter enable (bit 2 at 0x70) clear, every sensor code becomes a result. With it set, each result is the sum of 2^(type+1) consecutive codes shifted right by type+1, truncating. The type field is bits 1:0 of 0x70.
- R4: The data register at 0x80 holds the latest result in its low CODE_W bits and reads zero until the first result. Writes to it have no effect.
- R5: Status at 0x48 holds four sticky flags: alarm at bit 0, shutdown at bit 4, data-ready at bit 8 and alarm-release at bit 12. Data-ready sets on every result. Writing 1 to a flag clears it, and a set in the same cycle wins.
- R6: The alarm flag sets, and the alarm becomes armed, when a result is at or below the alarm code (bits 27:16 of 0x50). The alarm-release flag sets, and disarms the alarm, when a later result in the armed state is at or above the release code (bits 11:0 of 0x50) without meeting the alarm condition.
- R7: The shutdown flag sets when a result is at or below the shutdown code (bits 27:16 of 0x60).
- R8: `irq` is the OR of each pending flag ANDed with its enable. The enables sit at 0x44: alarm at bit 0, shutdown at bit 4, data-ready at bit 8. The alarm-release flag uses the alarm enable.
- R9: While sensing is off, no `acq_req` is issued and no status flag sets. The interval counter and the averaging state restart from zero.
- R10: The two acquisition-time fields (bits 15:0 of 0x00 and bits 31:16 of 0x40) and all other fields read back as written. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| adc_valid | input | 1 | Sensor code valid |
| adc_code | input | CODE_W | Raw sensor code |
| acq_req | output | 1 | One-cycle acquisition request |
| irq | output | 1 | Level interrupt |

## Verification
A stuck or miscounted interval counter shows on `acq_req` within one interval: the pulse arrives a cycle early or late, or it lasts two cycles. A wrong averaging count or shift shows as a data-register value that differs from the mean of the codes the bench sent, at the first result. A corrupt alarm-armed state or compare shows in status and `irq` in the cycle after the offending result is published. Because of this, the reference model compares `acq_req`, `irq` and the read data on every clock.

// File: rtl/thermo_pkg.sv
package thermo_pkg;
    localparam logic [7:0] A_CTRL0 = 8'h00;
    localparam logic [7:0] A_CTRL2 = 8'h40;
    localparam logic [7:0] A_INTC  = 8'h44;
    localparam logic [7:0] A_STAT  = 8'h48;
    localparam logic [7:0] A_ALARM = 8'h50;
    localparam logic [7:0] A_SHUT  = 8'h60;
    localparam logic [7:0] A_FILT  = 8'h70;
    localparam logic [7:0] A_DATA  = 8'h80;

    // status flag index i appears on the bus at bit 4*i
    localparam int ST_ALM = 0;
    localparam int ST_SHD = 1;
    localparam int ST_RDY = 2;
    localparam int ST_OFF = 3;
    localparam int ST_N   = 4;
    localparam int IE_N   = 3;

    localparam int ACQ_W  = 16;
    localparam int FT_W   = 2;
endpackage

// File: rtl/thermo_sched.sv
module thermo_sched #(
    parameter int PER_W     = 16,
    parameter int UNIT_LOG2 = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PER_W-1:0] per,
    output logic             acq_req
);
    localparam int CNT_W = PER_W + UNIT_LOG2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             req;
    } sched_t;

    sched_t s_q, s_d;
    logic [CNT_W-1:0] lim;
    logic             hit;

    // (per+1)*2^UNIT_LOG2 - 1
    assign lim = {per, {UNIT_LOG2{1'b1}}};
    assign hit = (s_q.cnt == lim);

    always_comb begin
        s_d = '0;
        if (en) begin
            s_d.req = hit;
            s_d.cnt = hit ? '0 : s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign acq_req = s_q.req;
endmodule

// File: rtl/thermo_avg.sv
module thermo_avg
    import thermo_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              filt_en,
    input  logic [FT_W-1:0]   filt_type,
    input  logic              adc_valid,
    input  logic [CODE_W-1:0] adc_code,
    output logic              res_valid,
    output logic [CODE_W-1:0] res_code
);
    localparam int MAX_SH = 1 << FT_W;
    localparam int CNT_W  = MAX_SH;
    localparam int ACC_W  = CODE_W + MAX_SH;

    typedef struct packed {
        logic [ACC_W-1:0]  acc;
        logic [CNT_W-1:0]  cnt;
        logic              vld;
        logic [CODE_W-1:0] res;
    } avg_t;

    avg_t a_q, a_d;
    logic [FT_W:0]    sh;
    logic [CNT_W:0]   n_full;
    logic [CNT_W-1:0] n_m1;
    logic [ACC_W-1:0] sum;

    assign sh     = filt_en ? (FT_W+1)'(filt_type) + (FT_W+1)'(1) : '0;
    assign n_full = (CNT_W+1)'(1) << sh;
    assign n_m1   = CNT_W'(n_full - (CNT_W+1)'(1));
    assign sum    = a_q.acc + ACC_W'(adc_code);

    always_comb begin
        a_d     = a_q;
        a_d.vld = 1'b0;
        if (!en) begin
            a_d = '0;
        end else if (adc_valid) begin
            if (a_q.cnt == n_m1) begin
                a_d.res = CODE_W'(sum >> sh);
                a_d.vld = 1'b1;
                a_d.acc = '0;
                a_d.cnt = '0;
            end else begin
                a_d.acc = sum;
                a_d.cnt = a_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign res_valid = a_q.vld;
    assign res_code  = a_q.res;
endmodule

// File: rtl/thermo_regs.sv
module thermo_regs
    import thermo_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int PER_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              res_valid,
    input  logic [CODE_W-1:0] res_code,
    output logic              sense_en,
    output logic [PER_W-1:0]  per,
    output logic              filt_en,
    output logic [FT_W-1:0]   filt_type,
    output logic [ST_N-1:0]   stat,
    output logic              armed,
    output logic [CODE_W-1:0] data,
    output logic              irq
);
    typedef struct packed {
        logic              en;
        logic [ACQ_W-1:0]  acq0;
        logic [ACQ_W-1:0]  acq1;
        logic [IE_N-1:0]   ie;
        logic [PER_W-1:0]  per;
        logic [CODE_W-1:0] hyst;
        logic [CODE_W-1:0] hot;
        logic [CODE_W-1:0] shut;
        logic              ften;
        logic [FT_W-1:0]   ftype;
        logic [ST_N-1:0]   stat;
        logic              armed;
        logic [CODE_W-1:0] data;
    } regs_t;

    regs_t r_q, r_d;
    logic [ST_N-1:0] clr, set;
    logic            take;

    always_comb begin
        r_d  = r_q;
        clr  = '0;
        set  = '0;
        take = res_valid & r_q.en;
        if (bus_wr) begin
            case (bus_addr)
                A_CTRL0: r_d.acq0 = bus_wdata[ACQ_W-1:0];
                A_CTRL2: begin
                    r_d.en   = bus_wdata[0];
                    r_d.acq1 = bus_wdata[31:16];
                end
                A_INTC: begin
                    for (int i = 0; i < IE_N; i++) r_d.ie[i] = bus_wdata[4*i];
                    r_d.per = bus_wdata[12 +: PER_W];
                end
                A_STAT: begin
                    for (int i = 0; i < ST_N; i++) clr[i] = bus_wdata[4*i];
                end
                A_ALARM: begin
                    r_d.hyst = bus_wdata[CODE_W-1:0];
                    r_d.hot  = bus_wdata[16 +: CODE_W];
                end
                A_SHUT: r_d.shut = bus_wdata[16 +: CODE_W];
                A_FILT: begin
                    r_d.ftype = bus_wdata[FT_W-1:0];
                    r_d.ften  = bus_wdata[2];
                end
                default: ;
            endcase
        end
        if (take) begin
            r_d.data    = res_code;
            set[ST_RDY] = 1'b1;
            if (res_code <= r_q.hot) begin
                set[ST_ALM] = 1'b1;
                r_d.armed   = 1'b1;
            end else if (r_q.armed && (res_code >= r_q.hyst)) begin
                set[ST_OFF] = 1'b1;
                r_d.armed   = 1'b0;
            end
            if (res_code <= r_q.shut) set[ST_SHD] = 1'b1;
        end
        r_d.stat = (r_q.stat & ~clr) | set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL0: bus_rdata[ACQ_W-1:0] = r_q.acq0;
            A_CTRL2: begin
                bus_rdata[0]     = r_q.en;
                bus_rdata[31:16] = r_q.acq1;
            end
            A_INTC: begin
                for (int i = 0; i < IE_N; i++) bus_rdata[4*i] = r_q.ie[i];
                bus_rdata[12 +: PER_W] = r_q.per;
            end
            A_STAT: begin
                for (int i = 0; i < ST_N; i++) bus_rdata[4*i] = r_q.stat[i];
            end
            A_ALARM: begin
                bus_rdata[CODE_W-1:0]  = r_q.hyst;
                bus_rdata[16 +: CODE_W] = r_q.hot;
            end
            A_SHUT: bus_rdata[16 +: CODE_W] = r_q.shut;
            A_FILT: begin
                bus_rdata[FT_W-1:0] = r_q.ftype;
                bus_rdata[2]        = r_q.ften;
            end
            A_DATA: bus_rdata[CODE_W-1:0] = r_q.data;
            default: ;
        endcase
    end

    assign irq = (|(r_q.stat[IE_N-1:0] & r_q.ie)) | (r_q.stat[ST_OFF] & r_q.ie[ST_ALM]);

    assign sense_en  = r_q.en;
    assign per       = r_q.per;
    assign filt_en   = r_q.ften;
    assign filt_type = r_q.ftype;
    assign stat      = r_q.stat;
    assign armed     = r_q.armed;
    assign data      = r_q.data;
endmodule

// File: rtl/thermo_sample_ctrl.sv
module thermo_sample_ctrl
    import thermo_pkg::*;
#(
    parameter int CODE_W    = 12,
    parameter int PER_W     = 16,
    parameter int UNIT_LOG2 = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              adc_valid,
    input  logic [CODE_W-1:0] adc_code,
    output logic              acq_req,
    output logic              irq
);
    logic              sense_en;
    logic [PER_W-1:0]  per;
    logic              filt_en;
    logic [FT_W-1:0]   filt_type;
    logic              res_valid;
    logic [CODE_W-1:0] res_code;
    logic [ST_N-1:0]   stat;
    logic              armed;
    logic [CODE_W-1:0] data;

    thermo_regs #(.CODE_W(CODE_W), .PER_W(PER_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .res_valid (res_valid),
        .res_code  (res_code),
        .sense_en  (sense_en),
        .per       (per),
        .filt_en   (filt_en),
        .filt_type (filt_type),
        .stat      (stat),
        .armed     (armed),
        .data      (data),
        .irq       (irq)
    );

    thermo_sched #(.PER_W(PER_W), .UNIT_LOG2(UNIT_LOG2)) u_sched (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (sense_en),
        .per     (per),
        .acq_req (acq_req)
    );

    thermo_avg #(.CODE_W(CODE_W)) u_avg (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (sense_en),
        .filt_en   (filt_en),
        .filt_type (filt_type),
        .adc_valid (adc_valid),
        .adc_code  (adc_code),
        .res_valid (res_valid),
        .res_code  (res_code)
    );
endmodule

// File: rtl/thermo_sample_chk.sv
module thermo_sample_chk
    import thermo_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              acq_req,
    input logic              irq,
    input logic [ST_N-1:0]   stat,
    input logic              armed,
    input logic              res_valid,
    input logic [CODE_W-1:0] data,
    input logic              bus_wr,
    input logic [7:0]        bus_addr,
    input logic              clr_rdy
);
    a_r2_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        acq_req |=> !acq_req);

    a_r9_no_req_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !acq_req);

    a_r9_no_flag_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !$rose(stat[ST_RDY]));

    a_r8_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat != '0));

    a_r4_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && en) |=> $stable(data));

    a_r5_clear_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_STAT && clr_rdy && !(res_valid && en)) |=> !stat[ST_RDY]);

    a_r6_release_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[ST_OFF]) |-> $past(armed));
endmodule

bind thermo_sample_ctrl thermo_sample_chk #(.CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (sense_en),
    .acq_req   (acq_req),
    .irq       (irq),
    .stat      (stat),
    .armed     (armed),
    .res_valid (res_valid),
    .data      (data),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .clr_rdy   (bus_wdata[8])
);

// File: tb/thermo_sample_ctrl_test.sv
module thermo_sample_ctrl_test;
    localparam int CW = 12;
    localparam int PW = 16;
    localparam int UL = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = 8'h48;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          adc_valid = 1'b0;
    logic [CW-1:0] adc_code = '0;
    logic          acq_req;
    logic          irq;

    thermo_sample_ctrl #(.CODE_W(CW), .PER_W(PW), .UNIT_LOG2(UL)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .adc_valid(adc_valid),
        .adc_code(adc_code), .acq_req(acq_req), .irq(irq)
    );

    always #5 clk = ~clk;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_en, m_acq0, m_acq1, m_per, m_hyst, m_hot, m_shut, m_ften, m_ftype;
    int m_armed, m_data, m_cnt, m_req, m_resv, m_res;
    logic [2:0] m_ie;
    logic [3:0] m_stat, m_set, m_clr;
    int m_q[$];
    int n_avg, sum;

    function automatic logic [31:0] m_rd(input logic [7:0] a);
        logic [31:0] r = '0;
        case (a)
            8'h00: r = 32'(m_acq0);
            8'h40: r = (32'(m_acq1) << 16) | 32'(m_en);
            8'h44: r = (32'(m_per) << 12) | {23'd0, m_ie[2], 3'd0, m_ie[1], 3'd0, m_ie[0]};
            8'h48: r = {19'd0, m_stat[3], 3'd0, m_stat[2], 3'd0, m_stat[1], 3'd0, m_stat[0]};
            8'h50: r = (32'(m_hot) << 16) | 32'(m_hyst);
            8'h60: r = 32'(m_shut) << 16;
            8'h70: r = 32'(m_ftype) | (32'(m_ften) << 2);
            8'h80: r = 32'(m_data);
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic m_irq();
        return (|(m_stat[2:0] & m_ie)) | (m_stat[3] & m_ie[0]);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_acq0 = 0; m_acq1 = 0; m_per = 0; m_hyst = 0; m_hot = 0;
            m_shut = 0; m_ften = 0; m_ftype = 0; m_armed = 0; m_data = 0;
            m_cnt = 0; m_req = 0; m_resv = 0; m_res = 0; m_ie = 0; m_stat = 0;
            m_q.delete();
        end else begin
            m_set = 0; m_clr = 0;
            // publish the previous result
            if (m_en != 0 && m_resv != 0) begin
                m_data = m_res;
                m_set[2] = 1;
                if (m_res <= m_hot) begin m_set[0] = 1; m_armed = 1; end
                else if (m_armed != 0 && m_res >= m_hyst) begin m_set[3] = 1; m_armed = 0; end
                if (m_res <= m_shut) m_set[1] = 1;
            end
            // averaging
            m_resv = 0;
            if (m_en == 0) m_q.delete();
            else if (adc_valid) begin
                m_q.push_back(int'(adc_code));
                n_avg = (m_ften != 0) ? (2 << m_ftype) : 1;
                if (m_q.size() == n_avg) begin
                    sum = 0;
                    foreach (m_q[k]) sum += m_q[k];
                    m_res = sum / n_avg;
                    m_resv = 1;
                    m_q.delete();
                end
            end
            // interval
            if (m_en == 0) begin m_cnt = 0; m_req = 0; end
            else begin
                m_req = (m_cnt == ((m_per + 1) << UL) - 1) ? 1 : 0;
                m_cnt = (m_req != 0) ? 0 : m_cnt + 1;
            end
            // register writes
            if (bus_wr) begin
                case (bus_addr)
                    8'h00: m_acq0 = int'(bus_wdata[15:0]);
                    8'h40: begin m_en = int'(bus_wdata[0]); m_acq1 = int'(bus_wdata[31:16]); end
                    8'h44: begin m_ie = {bus_wdata[8], bus_wdata[4], bus_wdata[0]}; m_per = int'(bus_wdata[27:12]); end
                    8'h48: m_clr = {bus_wdata[12], bus_wdata[8], bus_wdata[4], bus_wdata[0]};
                    8'h50: begin m_hyst = int'(bus_wdata[11:0]); m_hot = int'(bus_wdata[27:16]); end
                    8'h60: m_shut = int'(bus_wdata[27:16]);
                    8'h70: begin m_ftype = int'(bus_wdata[1:0]); m_ften = int'(bus_wdata[2]); end
                    default: ;
                endcase
            end
            m_stat = (m_stat & ~m_clr) | m_set;
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(acq_req == m_req[0], "R2 acq_req vs model", 32'(acq_req), 32'(m_req));
            check(irq == m_irq(), "R8 irq vs model", 32'(irq), 32'(m_irq()));
            check(bus_rdata == m_rd(bus_addr), "R10 read data vs model", bus_rdata, m_rd(bus_addr));
        end
    end

    // ---------------- sensor responder ----------------
    int base = 12'h700;
    bit tog = 0;
    always @(posedge clk) begin
        #1;
        if (acq_req) begin
            adc_valid = 1'b1;
            adc_code  = CW'(tog ? base + 32 : base);
            tog = ~tog;
        end else begin
            adc_valid = 1'b0;
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_addr = 8'h48; bus_wdata = '0;
    endtask

    task automatic rd_bits(input logic [7:0] a, input logic [31:0] mask, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        check((bus_rdata & mask) == exp, tag, bus_rdata & mask, exp);
        @(posedge clk); #1;
        bus_addr = 8'h48;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        int gap;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd_bits(8'h48, '1, 32'h0, "R1 status after reset");
        rd_bits(8'h80, '1, 32'h0, "R1 data after reset");
        rd_bits(8'h44, '1, 32'h0, "R1 interrupt control after reset");
        @(negedge clk);
        check(irq == 1'b0, "R1 irq after reset", 32'(irq), 32'h0);

        // R10 field readback
        wr(8'h00, 32'h0000ABCD);
        rd_bits(8'h00, '1, 32'h0000ABCD, "R10 acquisition field 0");
        wr(8'h40, 32'h00FF0000);
        rd_bits(8'h40, '1, 32'h00FF0000, "R10 acquisition field 1");
        rd_bits(8'h08, '1, 32'h0, "R10 unmapped address");

        wr(8'h50, 32'h0400_0500);
        wr(8'h60, 32'h0200_0000);
        wr(8'h44, 32'h0000_2111);
        rd_bits(8'h44, '1, 32'h0000_2111, "R2 period field readback");

        // R4 write to data ignored
        wr(8'h80, 32'h0000_0FFF);
        rd_bits(8'h80, '1, 32'h0, "R4 data write ignored");

        // R2 interval
        base = 12'h700;
        wr(8'h40, 32'h00FF0001);
        do @(negedge clk); while (!acq_req);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!acq_req);
        check(gap == 48, "R2 request interval", 32'(gap), 32'd48);

        idle(150);
        rd_bits(8'h48, 32'h100, 32'h100, "R5 data-ready set");
        @(negedge clk);
        check(irq == 1'b1, "R8 irq on data-ready", 32'(irq), 32'h1);
        @(posedge clk); #1 bus_addr = 8'h80;
        @(negedge clk);
        check(bus_rdata == 32'h700 || bus_rdata == 32'h720, "R3 unfiltered result", bus_rdata, 32'h700);

        // R5 clear, R9 off
        wr(8'h40, 32'h00FF0000);
        wr(8'h48, 32'h1111);
        rd_bits(8'h48, '1, 32'h0, "R5 write-one clears");
        @(negedge clk);
        check(irq == 1'b0, "R8 irq low when clear", 32'(irq), 32'h0);
        idle(200);
        rd_bits(8'h48, '1, 32'h0, "R9 no flags while off");

        // R6 alarm
        base = 12'h3F0;
        wr(8'h40, 32'h00FF0001);
        idle(150);
        rd_bits(8'h48, 32'h11, 32'h01, "R6 alarm set, R7 shutdown clear");
        // R7 shutdown
        base = 12'h1F0;
        idle(150);
        rd_bits(8'h48, 32'h10, 32'h10, "R7 shutdown set");
        // R6 release
        base = 12'h600;
        idle(150);
        rd_bits(8'h48, 32'h1000, 32'h1000, "R6 alarm release set");

        // R8 masking: only alarm enabled, cool codes
        wr(8'h40, 32'h00FF0000);
        wr(8'h48, 32'h1111);
        wr(8'h44, 32'h0000_2001);
        base = 12'h700;
        wr(8'h40, 32'h00FF0001);
        idle(150);
        rd_bits(8'h48, 32'h100, 32'h100, "R8 data-ready pending while masked");
        @(negedge clk);
        check(irq == 1'b0, "R8 masked flag keeps irq low", 32'(irq), 32'h0);

        // R3 filter, 2 samples
        wr(8'h40, 32'h00FF0000);
        wr(8'h48, 32'h1111);
        wr(8'h70, 32'h4);
        base = 12'h600;
        wr(8'h40, 32'h00FF0001);
        idle(150);
        rd_bits(8'h80, '1, 32'h610, "R3 mean of 2");

        // R3 filter, 8 samples
        wr(8'h40, 32'h00FF0000);
        wr(8'h70, 32'h6);
        base = 12'h700;
        wr(8'h40, 32'h00FF0001);
        idle(900);
        rd_bits(8'h80, '1, 32'h710, "R3 mean of 8");
        wr(8'h40, 32'h00FF0000);
        idle(20);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++;
            nerr++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule